// File: doc/BRIEF.md
# Streaming Column Mask Projector

The projector sits in a row stream where every table row arrives as a sequence of 32-bit words, one word per column, starting at column 0. A configuration port loads a per-column keep mask and the row's column count. Each incoming word is then either forwarded or discarded on the spot. Nothing is buffered, so the output is a projected table with the same row order and fewer columns.

Both stream ports use a valid/ready handshake. Data passes through combinationally, so there is no cycle of latency. A discarded word is taken from the source even while the sink stalls. A kept word is taken only when the sink accepts it. The block counts columns itself. It flags the last kept column of every row on the output last signal. It refuses a configuration that would keep no column.

Top module: `col_projector`

## Requirements
- R1: After reset the block is unconfigured: in_ready_o=0, out_valid_o=0, cfg_err_o=0.
- R2: A word of column c is forwarded with unchanged data when bit c of the mask is 1 and c < column count.
- R3: A word whose column is not kept is consumed (in_ready_o=1) with out_valid_o=0, whatever out_ready_i is.
- R4: A kept word is consumed only in a cycle where out_ready_i=1. While it is stalled, in_ready_o=0 and the column index does not advance.
- R5: The column index starts at 0 and advances on each consumed word. After column count-1 it returns to 0, so every row repeats the same pattern.
- R6: out_last_o=1 exactly on the forwarded word of the highest-numbered kept column of each row.
- R7: A configuration with column count 0, column count above 32, or no mask bit set below the column count sets cfg_err_o=1. While cfg_err_o=1, out_valid_o=0 and in_ready_o=0.
- R8: Mask bits at index column count or higher have no effect on forwarding or on out_last_o.
- R9: Loading a valid configuration clears cfg_err_o and restarts the column index at 0, even in the middle of a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Load mask and column count this cycle |
| cfg_mask_i | input | 32 | Keep mask, bit i for column i |
| cfg_ncols_i | input | 6 | Columns per row, 1 to 32 |
| cfg_err_o | output | 1 | Last loaded configuration was rejected |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word consumed |
| in_data_i | input | 32 | Input column word |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Sink accepts output word |
| out_data_o | output | 32 | Output column word |
| out_last_o | output | 1 | Output word is the final kept column of its row |

## Verification
A table of masks is run over two rows each. The table covers sparse masks with gaps, a mask with only the first and last of 32 columns set, a single one-column row, a mask that is full, and masks whose stray high bits lie beyond the column count. Together these separate a correct column index and wrap from an off-by-one, and a correct last-column flag from one taken from the raw mask. Directed stalls show a discarded word passing while the sink holds off, and a kept word holding in place. Empty, zero-width and oversize configurations, followed by a reload in the middle of a row, show the error gating and the restart of the column index.

// File: rtl/colproj_pkg.sv
package colproj_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned MAX_COLS = 32;
endpackage

// File: rtl/colproj_cfg.sv
module colproj_cfg #(
  parameter int unsigned MAX_COLS = 32,
  localparam int unsigned COL_W = $clog2(MAX_COLS),
  localparam int unsigned CNT_W = COL_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [MAX_COLS-1:0] mask_i,
  input  logic [CNT_W-1:0]    ncols_i,
  output logic [MAX_COLS-1:0] mask_o,
  output logic [COL_W-1:0]    maxcol_o,
  output logic [COL_W-1:0]    lastcol_o,
  output logic                ok_o,
  output logic                err_o
);
  logic [MAX_COLS-1:0] eff;
  logic [COL_W-1:0]    hi;
  logic                width_ok, ok_d;

  // clip mask to configured width
  for (genvar i = 0; i < MAX_COLS; i++) begin : g_clip
    assign eff[i] = mask_i[i] & (CNT_W'(i) < ncols_i);
  end

  always_comb begin
    hi = '0;
    for (int i = 0; i < MAX_COLS; i++)
      if (eff[i]) hi = COL_W'(i);
  end

  assign width_ok = (ncols_i != '0) && (ncols_i <= CNT_W'(MAX_COLS));
  assign ok_d     = width_ok && (|eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o    <= '0;
      maxcol_o  <= '0;
      lastcol_o <= '0;
      ok_o      <= 1'b0;
      err_o     <= 1'b0;
    end else if (load_i) begin
      mask_o    <= eff;
      maxcol_o  <= COL_W'(ncols_i - 1'b1);
      lastcol_o <= hi;
      ok_o      <= ok_d;
      err_o     <= !ok_d;
    end
  end

  assert_last_in_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (lastcol_o <= maxcol_o));

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !width_ok |=> err_o && !ok_o);
endmodule

// File: rtl/colproj_col_ctr.sv
module colproj_col_ctr #(
  parameter int unsigned MAX_COLS = 32,
  localparam int unsigned COL_W = $clog2(MAX_COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [COL_W-1:0] maxcol_i,
  output logic [COL_W-1:0] col_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               col_o <= '0;
    else if (clear_i)          col_o <= '0;
    else if (step_i)           col_o <= (col_o == maxcol_i) ? '0 : col_o + 1'b1;
  end

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clear_i && (col_o == maxcol_i) |=> col_o == '0);

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> col_o == '0);
endmodule

// File: rtl/col_projector.sv
module col_projector
  import colproj_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned NCOLS  = MAX_COLS,
  localparam int unsigned COL_W = $clog2(NCOLS),
  localparam int unsigned CNT_W = COL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [NCOLS-1:0]  cfg_mask_i,
  input  logic [CNT_W-1:0]  cfg_ncols_i,
  output logic              cfg_err_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o
);
  logic [NCOLS-1:0] mask_q;
  logic [COL_W-1:0] maxcol_q, lastcol_q, col_q;
  logic             ok_q, keep;

  colproj_cfg #(.MAX_COLS(NCOLS)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cfg_valid_i),
    .mask_i    (cfg_mask_i),
    .ncols_i   (cfg_ncols_i),
    .mask_o    (mask_q),
    .maxcol_o  (maxcol_q),
    .lastcol_o (lastcol_q),
    .ok_o      (ok_q),
    .err_o     (cfg_err_o)
  );

  colproj_col_ctr #(.MAX_COLS(NCOLS)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (cfg_valid_i),
    .step_i   (in_valid_i && in_ready_o),
    .maxcol_i (maxcol_q),
    .col_o    (col_q)
  );

  assign keep        = mask_q[col_q];
  assign out_valid_o = ok_q && in_valid_i && keep;
  assign in_ready_o  = ok_q && (!keep || out_ready_i);
  assign out_data_o  = in_data_i;
  assign out_last_o  = keep && (col_q == lastcol_q);

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  assert_err_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !out_valid_o && !in_ready_o);

  assert_drop_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !out_valid_o |-> !out_last_o);
endmodule

// File: tb/col_projector_tb_top.sv
module col_projector_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_valid_i = 1'b0;
  logic [31:0] cfg_mask_i = '0;
  logic [5:0]  cfg_ncols_i = '0;
  logic        cfg_err_o;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic        out_last_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  col_projector dut_i (.*);

  // {ncols[5:0], mask[31:0]}
  localparam int NV = 7;
  localparam logic [37:0] VECS [NV] = '{
    {6'd4,  32'h0000_0005},
    {6'd32, 32'h8000_0001},
    {6'd1,  32'h0000_0001},
    {6'd5,  32'hFFFF_FFF0},
    {6'd32, 32'hFFFF_FFFF},
    {6'd7,  32'h0000_0F2A},
    {6'd3,  32'hFFFF_FFFA}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [31:0] m, input logic [5:0] n);
    @(negedge clk_i);
    cfg_valid_i = 1'b1; cfg_mask_i = m; cfg_ncols_i = n;
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
  endtask

  // one word presented; we are just after a negedge
  task automatic word(input logic [31:0] d, input bit exp_v, input bit exp_last,
                      input bit exp_rdy, input string tag);
    in_valid_i = 1'b1; in_data_i = d;
    #1;
    chk(out_valid_o == exp_v, {tag, " valid"}, 32'(out_valid_o), 32'(exp_v));
    if (exp_v) begin
      chk(out_data_o == d, {tag, " data"}, out_data_o, d);
      chk(out_last_o == exp_last, {tag, " last"}, 32'(out_last_o), 32'(exp_last));
    end
    chk(in_ready_o == exp_rdy, {tag, " ready"}, 32'(in_ready_o), 32'(exp_rdy));
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #12;
    chk(in_ready_o == 1'b0 && out_valid_o == 1'b0 && cfg_err_o == 1'b0,
        "R1 reset", {29'd0, in_ready_o, out_valid_o, cfg_err_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b1; #1;
    chk(in_ready_o == 1'b0 && out_valid_o == 1'b0, "R1 unconfigured",
        {30'd0, in_ready_o, out_valid_o}, 32'd0);
    in_valid_i = 1'b0;

    // table walk: R2 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic [5:0]  n;
      logic [31:0] m;
      int hi;
      n = VECS[v][37:32]; m = VECS[v][31:0];
      hi = -1;
      for (int c = 0; c < 32; c++) if (m[c] && c < n) hi = c;
      load_cfg(m, n);
      chk(cfg_err_o == 1'b0, "R7 accepted cfg", 32'(cfg_err_o), 32'd0);
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < n; c++) begin
          bit k;
          k = m[c];
          word({v[7:0], r[7:0], c[15:0]}, k, (c == hi), 1'b1, "R2/R5/R6/R8 table");
        end
    end

    // R3/R4 stalls: ncols=3, keep column 1
    load_cfg(32'h0000_0002, 6'd3);
    out_ready_i = 1'b0;
    word(32'hA000_0000, 1'b0, 1'b0, 1'b1, "R3 drop under stall");
    word(32'hA000_0001, 1'b1, 1'b1, 1'b0, "R4 kept stalled");
    word(32'hA000_0001, 1'b1, 1'b1, 1'b0, "R4 kept still held");
    out_ready_i = 1'b1;
    word(32'hA000_0001, 1'b1, 1'b1, 1'b1, "R4 kept released");
    out_ready_i = 1'b0;
    word(32'hA000_0002, 1'b0, 1'b0, 1'b1, "R3 col2 drop under stall");
    out_ready_i = 1'b1;
    word(32'hA000_0010, 1'b0, 1'b0, 1'b1, "R5 next row col0");

    // R7 rejected configurations
    load_cfg(32'hFFFF_FF00, 6'd8);
    chk(cfg_err_o == 1'b1, "R7 empty mask", 32'(cfg_err_o), 32'd1);
    word(32'hB000_0000, 1'b0, 1'b0, 1'b0, "R7 quiet on error");
    load_cfg(32'hFFFF_FFFF, 6'd0);
    chk(cfg_err_o == 1'b1, "R7 zero cols", 32'(cfg_err_o), 32'd1);
    load_cfg(32'hFFFF_FFFF, 6'd33);
    chk(cfg_err_o == 1'b1, "R7 too many cols", 32'(cfg_err_o), 32'd1);
    word(32'hB000_0001, 1'b0, 1'b0, 1'b0, "R7 quiet on oversize");

    // R9 reload clears error and restarts mid-row
    load_cfg(32'h0000_0008, 6'd4);
    chk(cfg_err_o == 1'b0, "R9 error cleared", 32'(cfg_err_o), 32'd0);
    word(32'hC000_0000, 1'b0, 1'b0, 1'b1, "R9 pre col0");
    word(32'hC000_0001, 1'b0, 1'b0, 1'b1, "R9 pre col1");
    load_cfg(32'h0000_0008, 6'd4);
    word(32'hC000_0010, 1'b0, 1'b0, 1'b1, "R9 restart col0");
    word(32'hC000_0011, 1'b0, 1'b0, 1'b1, "R9 restart col1");
    word(32'hC000_0012, 1'b0, 1'b0, 1'b1, "R9 restart col2");
    word(32'hC000_0013, 1'b1, 1'b1, 1'b1, "R9 restart col3");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule